// File: doc/BRIEF.md
# Low-Power Run Mode Sequencer

This block moves a device between normal run, powered by the main voltage regulator, and a low-power run mode in which a small low-power regulator supplies the core instead. Software raises a request bit. The sequencer then checks that the clock configuration is safe for the weak regulator: the bus clock must be slow enough, the external crystal oscillator must be off, and the PLL must be off. Only when all of these hold does it switch on the low-power regulator. It waits for that regulator's ready handshake, turns the main regulator off, and raises the low-power-run status flag. The internal 16 MHz oscillator is not part of the check, because it may keep running as a peripheral kernel clock.

When software clears the request, the sequence runs in reverse. The main regulator is enabled again. The low-power-run flag stays set until the main regulator reports ready, and only then does the low-power regulator switch off. While the low-power mode is active, or while the sequencer is leaving it, any software attempt to enable the PLL or the external oscillator is masked.

Both regulator-ready inputs come from other supply domains, so each passes through a two-flop synchroniser before the state machine uses it. No data streams through the block. Every pin is a plain level control or status signal with no valid/ready handshake and no back-pressure. The request is a level: holding it high asks for the low-power mode, and dropping it asks for normal run.

Top module: `lpr_seq`

## Requirements
- R1: After reset, mainreg_en_o=1, lpreg_en_o=0, lprun_flag_o=0, err_flag_o=0 and lpreg_rdy_flag_o=0.
- R2: The bus clock is sysclk_khz_i shifted right by hclk_shift_i bits. Entry is allowed only when this value is at most LIMIT_KHZ (default 2000). A value exactly equal to the limit is accepted, and one above it holds entry with lpreg_en_o low.
- R3: While hse_on_i=1 or pll_on_i=1, entry is held: lpreg_en_o stays 0 and lprun_flag_o stays 0.
- R4: err_flag_o becomes 1 when the request is high while the preconditions are violated. It then stays 1 until the request is cleared. Entry still proceeds once the preconditions become true.
- R5: After an accepted request, lpreg_en_o goes to 1 while mainreg_en_o stays 1. lprun_flag_o rises exactly three rising clock edges after lpreg_rdy_i goes high, and not before.
- R6: lpreg_rdy_flag_o shows the synchronised lpreg_rdy_i, two edges after the input changes. It is therefore high for one cycle before lprun_flag_o rises.
- R7: While lprun_flag_o=1 and the request is high, mainreg_en_o=0.
- R8: Clearing the request in low-power run sets mainreg_en_o=1 at once. lprun_flag_o stays 1 until three edges after mainreg_rdy_i goes high. It then falls, and lpreg_en_o falls with it.
- R9: hse_en_o and pll_en_o follow hse_en_req_i and pll_en_req_i, except that both are forced to 0 while lprun_flag_o=1.
- R10: If the request is withdrawn before the low-power regulator is ready, lpreg_en_o returns to 0 and lprun_flag_o never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lpr_req_i | input | 1 | Software request for low-power run (level) |
| sysclk_khz_i | input | 16 | Configured system clock in kHz |
| hclk_shift_i | input | 4 | Bus prescaler as a power-of-two shift |
| hse_on_i | input | 1 | External crystal oscillator running |
| pll_on_i | input | 1 | PLL running |
| hse_en_req_i | input | 1 | Software enable for the external oscillator |
| pll_en_req_i | input | 1 | Software enable for the PLL |
| hse_en_o | output | 1 | Gated external oscillator enable |
| pll_en_o | output | 1 | Gated PLL enable |
| lpreg_en_o | output | 1 | Low-power regulator enable |
| lpreg_rdy_i | input | 1 | Low-power regulator ready (asynchronous) |
| mainreg_en_o | output | 1 | Main regulator enable |
| mainreg_rdy_i | input | 1 | Main regulator ready (asynchronous) |
| lpreg_rdy_flag_o | output | 1 | Synchronised low-power regulator ready status |
| lprun_flag_o | output | 1 | Device is in low-power run |
| err_flag_o | output | 1 | Request made with preconditions violated |

## Verification
Random clock configurations vary the system clock, the prescale shift and the two oscillator states together. Each entry outcome is compared with a bench function, which separates the clock-limit rule from the oscillator rules. Directed cases set the bus clock to exactly 2000 and 2001 kHz, hold each regulator's ready signal low by hand to measure the synchroniser latency edge by edge, withdraw the request before the regulator is ready, and toggle the PLL and oscillator enables inside and outside low-power run.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_CHECK     = 3'd1,
    ST_WAIT_REG  = 3'd2,
    ST_LPRUN     = 3'd3,
    ST_EXIT_WAIT = 3'd4
  } lpr_state_t;
endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/lpr_precheck.sv
module lpr_precheck #(
  parameter int CLK_W     = 16,
  parameter int SHIFT_W   = 4,
  parameter int LIMIT_KHZ = 2000
) (
  input  logic [CLK_W-1:0]   sysclk_khz_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               hse_on_i,
  input  logic               pll_on_i,
  output logic               ok_o
);
  localparam logic [CLK_W-1:0] LIMIT_V = CLK_W'(LIMIT_KHZ);

  logic [CLK_W-1:0] bus_khz;
  logic             clk_ok;
  logic             osc_ok;

  assign bus_khz = sysclk_khz_i >> shift_i;
  assign clk_ok  = (bus_khz <= LIMIT_V);
  assign osc_ok  = !hse_on_i && !pll_on_i;
  assign ok_o    = clk_ok && osc_ok;
endmodule

// File: rtl/lpr_gate.sv
module lpr_gate #(
  parameter int N = 2
) (
  input  logic         block_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] en_o
);
  for (genvar i = 0; i < N; i++) begin : g_gate
    assign en_o[i] = req_i[i] && !block_i;
  end
endmodule

// File: rtl/lpr_fsm.sv
module lpr_fsm
  import lpr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic prec_ok_i,
  input  logic lp_rdy_s_i,
  input  logic main_rdy_s_i,
  output logic lpreg_en_o,
  output logic mainreg_en_o,
  output logic lprun_o,
  output logic block_o,
  output logic err_o
);
  lpr_state_t state_q, state_d;
  logic       err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:       if (req_i) state_d = ST_CHECK;
      ST_CHECK: begin
        if (!req_i)                        state_d = ST_RUN;
        else if (prec_ok_i && !lp_rdy_s_i) state_d = ST_WAIT_REG;
      end
      ST_WAIT_REG: begin
        if (!req_i)          state_d = ST_RUN;
        else if (!prec_ok_i) state_d = ST_CHECK;
        else if (lp_rdy_s_i) state_d = ST_LPRUN;
      end
      ST_LPRUN:     if (!req_i && !main_rdy_s_i) state_d = ST_EXIT_WAIT;
      ST_EXIT_WAIT: if (main_rdy_s_i) state_d = ST_RUN;
      default:      state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                  err_q <= 1'b0;
    else if (!req_i)                             err_q <= 1'b0;
    else if (state_q == ST_CHECK && !prec_ok_i)  err_q <= 1'b1;

  assign lpreg_en_o   = (state_q == ST_WAIT_REG) || (state_q == ST_LPRUN) ||
                        (state_q == ST_EXIT_WAIT);
  assign mainreg_en_o = (state_q != ST_LPRUN);
  assign lprun_o      = (state_q == ST_LPRUN) || (state_q == ST_EXIT_WAIT);
  assign block_o      = lprun_o;
  assign err_o        = err_q;

  // R5: low-power run is reported only once the synchronised LP ready is seen
  a_r5_lprun_after_lp_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lprun_o) |-> $past(lp_rdy_s_i));
  // R2 R3: the LP regulator is started only from a passing precondition check
  a_r2_start_needs_prec: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lpreg_en_o) |-> $past(prec_ok_i));
  // R4: error rises only when preconditions were violated
  a_r4_err_on_violation: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> ($past(!prec_ok_i) && $past(req_i)));
  // R8: leaving low-power run waits for the synchronised main ready
  a_r8_exit_on_main_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lprun_o) |-> $past(main_rdy_s_i));
  // R7: main regulator is off only while low-power run is reported
  a_r7_main_off_in_lprun: assert property (@(posedge clk) disable iff (!rst_n)
    !mainreg_en_o |-> lprun_o);
  // R8: LP regulator never switches off before the main one is back
  a_r8_lp_off_main_on: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lpreg_en_o) |-> mainreg_en_o);
endmodule

// File: rtl/lpr_seq.sv
module lpr_seq #(
  parameter int CLK_W     = 16,
  parameter int SHIFT_W   = 4,
  parameter int LIMIT_KHZ = 2000,
  parameter int SYNC_STG  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lpr_req_i,
  input  logic [CLK_W-1:0]   sysclk_khz_i,
  input  logic [SHIFT_W-1:0] hclk_shift_i,
  input  logic               hse_on_i,
  input  logic               pll_on_i,
  input  logic               hse_en_req_i,
  input  logic               pll_en_req_i,
  output logic               hse_en_o,
  output logic               pll_en_o,
  output logic               lpreg_en_o,
  input  logic               lpreg_rdy_i,
  output logic               mainreg_en_o,
  input  logic               mainreg_rdy_i,
  output logic               lpreg_rdy_flag_o,
  output logic               lprun_flag_o,
  output logic               err_flag_o
);
  localparam int NRDY  = 2;
  localparam int NGATE = 2;

  logic [NRDY-1:0]  rdy_s;
  logic             prec_ok;
  logic             block;
  logic [NGATE-1:0] gated;

  lpr_sync #(.W(NRDY), .STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({mainreg_rdy_i, lpreg_rdy_i}),
    .q_o   (rdy_s)
  );

  lpr_precheck #(.CLK_W(CLK_W), .SHIFT_W(SHIFT_W), .LIMIT_KHZ(LIMIT_KHZ)) u_pre (
    .sysclk_khz_i (sysclk_khz_i),
    .shift_i      (hclk_shift_i),
    .hse_on_i     (hse_on_i),
    .pll_on_i     (pll_on_i),
    .ok_o         (prec_ok)
  );

  lpr_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (lpr_req_i),
    .prec_ok_i    (prec_ok),
    .lp_rdy_s_i   (rdy_s[0]),
    .main_rdy_s_i (rdy_s[1]),
    .lpreg_en_o   (lpreg_en_o),
    .mainreg_en_o (mainreg_en_o),
    .lprun_o      (lprun_flag_o),
    .block_o      (block),
    .err_o        (err_flag_o)
  );

  lpr_gate #(.N(NGATE)) u_gate (
    .block_i (block),
    .req_i   ({pll_en_req_i, hse_en_req_i}),
    .en_o    (gated)
  );

  assign hse_en_o         = gated[0];
  assign pll_en_o         = gated[1];
  assign lpreg_rdy_flag_o = rdy_s[0];

  // R9: no clock source can be switched on during low-power run
  a_r9_no_enable_in_lprun: assert property (@(posedge clk) disable iff (!rst_n)
    lprun_flag_o |-> (!hse_en_o && !pll_en_o));
  // R3: low-power run never begins with a fast source running
  a_r3_osc_off_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lprun_flag_o) |-> $past(!hse_on_i && !pll_on_i));
endmodule

// File: tb/sim_lpr_seq.sv
module sim_lpr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] sysclk = 16'd16000;
  logic [3:0]  shift = 4'd3;
  logic        hse_on = 1'b0, pll_on = 1'b0;
  logic        hse_req = 1'b0, pll_req = 1'b0;
  logic        hse_en, pll_en, lp_en, main_en, lp_flag, lprun, err;
  logic        lp_rdy, main_rdy;
  logic        lp_man = 1'b0, lp_man_v = 1'b0, main_man = 1'b0, main_man_v = 1'b0;
  logic        lp_mod = 1'b0, main_mod = 1'b0;
  int          lp_cnt = 0, main_cnt = 0;
  int          n_chk = 0, n_bad = 0, cyc = 0;
  bit          done = 1'b0;
  localparam int DLY = 6;

  always #2 clk = ~clk;

  lpr_seq u0 (
    .clk(clk), .rst_n(rst_n), .lpr_req_i(req), .sysclk_khz_i(sysclk),
    .hclk_shift_i(shift), .hse_on_i(hse_on), .pll_on_i(pll_on),
    .hse_en_req_i(hse_req), .pll_en_req_i(pll_req), .hse_en_o(hse_en),
    .pll_en_o(pll_en), .lpreg_en_o(lp_en), .lpreg_rdy_i(lp_rdy),
    .mainreg_en_o(main_en), .mainreg_rdy_i(main_rdy),
    .lpreg_rdy_flag_o(lp_flag), .lprun_flag_o(lprun), .err_flag_o(err)
  );

  // regulator models: ready after DLY cycles of enable, drops with enable
  always @(posedge clk) begin
    if (!lp_en) begin lp_cnt <= 0; lp_mod <= 1'b0; end
    else if (lp_cnt >= DLY) lp_mod <= 1'b1;
    else lp_cnt <= lp_cnt + 1;
    if (!main_en) begin main_cnt <= 0; main_mod <= 1'b0; end
    else if (main_cnt >= DLY) main_mod <= 1'b1;
    else main_cnt <= main_cnt + 1;
  end
  assign lp_rdy   = lp_man   ? lp_man_v   : lp_mod;
  assign main_rdy = main_man ? main_man_v : main_mod;

  function automatic bit exp_ok(logic [15:0] s, logic [3:0] sh, logic h, logic p);
    return ((s >> sh) <= 16'd2000) && !h && !p;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        finish_run();
      end
    end
  end

  initial begin
    step(3);
    // R1 reset state
    chk("R1 main_en", main_en, 1); chk("R1 lp_en", lp_en, 0);
    chk("R1 lprun", lprun, 0);     chk("R1 err", err, 0);
    chk("R1 lp_flag", lp_flag, 0);
    rst_n = 1'b1;
    step(20);

    // R2 boundary: 16008>>3 = 2001 rejected
    sysclk = 16'd16008; shift = 4'd3; req = 1'b1;
    step(30);
    chk("R2 over limit lp_en", lp_en, 0); chk("R2 over limit lprun", lprun, 0);
    chk("R4 err set", err, 1);
    // R4: fix clock to exactly 2000, entry proceeds, err held
    sysclk = 16'd16000;
    step(30);
    chk("R2 at limit lprun", lprun, 1); chk("R4 err held", err, 1);
    chk("R7 main off", main_en, 0);
    req = 1'b0; step(30);
    chk("R4 err cleared", err, 0); chk("R8 back to run", lprun, 0);

    // R3: PLL on holds entry, then HSE on
    pll_on = 1'b1; req = 1'b1; step(30);
    chk("R3 pll blocks", lp_en, 0); chk("R3 pll lprun", lprun, 0);
    pll_on = 1'b0; hse_on = 1'b1; step(30);
    chk("R3 hse blocks", lprun, 0);
    hse_on = 1'b0; req = 1'b0; step(20);

    // R5 R6 exact entry latency with manual LP ready
    lp_man = 1'b1; lp_man_v = 1'b0; req = 1'b1; step(20);
    chk("R5 lp_en on", lp_en, 1); chk("R5 main still on", main_en, 1);
    chk("R5 no lprun yet", lprun, 0);
    lp_man_v = 1'b1; step(1);
    chk("R6 flag edge1", lp_flag, 0);
    step(1);
    chk("R6 flag edge2", lp_flag, 1); chk("R5 lprun edge2", lprun, 0);
    step(1);
    chk("R5 lprun edge3", lprun, 1);

    // R9 gating in low-power run
    hse_req = 1'b1; pll_req = 1'b1; step(1);
    chk("R9 hse masked", hse_en, 0); chk("R9 pll masked", pll_en, 0);

    // R8 exact exit latency with manual main ready
    step(10);
    main_man = 1'b1; main_man_v = 1'b0; req = 1'b0; step(1);
    chk("R8 main re-enabled", main_en, 1);
    step(20);
    chk("R8 lprun held", lprun, 1); chk("R9 still masked", pll_en, 0);
    main_man_v = 1'b1; step(2);
    chk("R8 lprun edge2", lprun, 1);
    step(1);
    chk("R8 lprun edge3", lprun, 0); chk("R8 lp off", lp_en, 0);
    chk("R9 pll passes", pll_en, 1); chk("R9 hse passes", hse_en, 1);
    hse_req = 1'b0; pll_req = 1'b0;
    main_man = 1'b0; lp_man_v = 1'b0; step(20);

    // R10 abort before LP ready
    req = 1'b1; step(20);
    chk("R10 waiting", lp_en, 1);
    req = 1'b0; step(2);
    chk("R10 aborted lp_en", lp_en, 0); chk("R10 no lprun", lprun, 0);
    lp_man = 1'b0; step(20);

    // random configurations against the bench function
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 40; k++) begin
      bit ok;
      sysclk = 16'($urandom_range(500, 48000));
      shift  = 4'($urandom_range(0, 7));
      hse_on = ($urandom_range(0, 3) == 0);
      pll_on = ($urandom_range(0, 3) == 0);
      ok = exp_ok(sysclk, shift, hse_on, pll_on);
      req = 1'b1; step(40);
      chk("R2 R3 rand lprun", lprun, ok);
      chk("R4 rand err", err, !ok);
      chk("R7 rand main", main_en, !ok);
      req = 1'b0; step(40);
      chk("R8 rand exit", lprun, 0);
      chk("R8 rand main", main_en, 1);
    end
    finish_run();
  end
endmodule